// File: doc/BRIEF.md
# Token-Gated PWM Latch with Break-Before-Make Drive

This block sits on the phase side of a multiphase buck controller. It holds one PWM set/reset latch. The latch turns on at a falling edge of the shared phase clock, and only when this phase holds the daisy-chain token. A digital compare trip turns it off. The trip stands in for the ramp comparator, and it always wins over a set in the same cycle. This lets the loop command zero duty. With no trip, the latch stays on across later clock pulses, so duty can reach 100 percent.

The latch state is turned into two gate enables that never overlap. On a turn-on, the low-side enable drops at once. The high-side enable rises only after a programmable gap counted in system clocks. A turn-off behaves the same way in mirror. A third output asks for the ramp capacitor to be discharged whenever the latch is off. The asynchronous active-low reset is released through a synchronizer. All internal state follows that synchronized reset.

Top module: `pwm_phase_latch`

## Requirements
- R1: A falling edge of `pwm_clk_i` sets the latch at the next rising `clk` edge when `token_i` is 1 in that cycle and `trip_i` is 0. A falling edge means `pwm_clk_i` was 1 in the previous cycle and is 0 in the current one. A set shows as `dis_en_o` going to 0.
- R2: No set happens without the token, on a rising edge of `pwm_clk_i`, or while `pwm_clk_i` stays at one level. In each of these cases `dis_en_o` stays 1 and `ls_en_o` stays 1.
- R3: When `trip_i` is 1 in a cycle, the latch is cleared at the next edge. From the following cycle `dis_en_o` is 1 and `hs_en_o` is 0.
- R4: Reset dominance: when a set condition and `trip_i` occur in the same cycle, the latch stays cleared (`dis_en_o` stays 1 and `hs_en_o` stays 0).
- R5: Once set and with no trip, the latch stays set across further falling edges of `pwm_clk_i`, and `hs_en_o` stays 1.
- R6: At the edge where the latch sets, `ls_en_o` goes to 0. `hs_en_o` goes to 1 exactly G cycles after that edge. G is the gap length taken from `dead_cfg_i` when the gap starts.
- R7: At the edge where the latch clears, `hs_en_o` goes to 0. `ls_en_o` goes to 1 exactly G cycles after that edge.
- R8: G equals `dead_cfg_i` read as an unsigned number, except that the value 0 gives G = 1.
- R9: `hs_en_o` and `ls_en_o` are never 1 in the same cycle. Each enable rises only after a cycle in which both were 0.
- R10: `dis_en_o` is 1 exactly while the latch is cleared, so it is never 1 together with `hs_en_o`.
- R11: While reset is asserted, `hs_en_o` = 0, `ls_en_o` = 0 and `dis_en_o` = 1. After release and a short gap, `ls_en_o` becomes 1.
- R12: A trip during a gap toward the high side cancels the turn-on. `hs_en_o` never rises, and `ls_en_o` rises G cycles after the edge that took the trip, because the gap restarts in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_clk_i | input | 1 | Shared phase clock pulse, already synchronous to `clk` |
| token_i | input | 1 | Daisy-chain token; gates the set |
| trip_i | input | 1 | Compare trip; clears the latch, dominant |
| dead_cfg_i | input | DT_W | Gap length in `clk` cycles; 0 means 1 |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| dis_en_o | output | 1 | Ramp discharge enable, 1 while the latch is cleared |

## Verification
The assertions check the per-cycle safety properties on every cycle:
- the two enables never overlap;
- each enable rises only after a cycle with both enables low;
- a trip takes the high side down and raises discharge in the next cycle;
- the latch can only set after a sampled falling clock with the token held and no trip.

Only the bench scenarios can show the exact gap length for every setting, including the forced minimum for zero. The same is true of token gating, of edge-only setting, of holding through further pulses, and of the full gap restart when a turn-on is aborted mid-gap.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;

  // Drive sequencer states; the gap states hold both enables low.
  typedef enum logic [1:0] {
    ST_LOW_ON      = 2'd0,
    ST_GAP_TO_HIGH = 2'd1,
    ST_HIGH_ON     = 2'd2,
    ST_GAP_TO_LOW  = 2'd3
  } drv_state_e;

endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q <= '0;
    end else begin
      shift_q <= shift_d;
    end
  end

  assign rst_sync_n = shift_q[STAGES-1];

endmodule

// File: rtl/pwm_fall_detect.sv
module pwm_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_i,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= pulse_i;
    end
  end

  // High in the cycle where the input has just gone from 1 to 0.
  assign fall_o = prev_q & ~pulse_i;

endmodule

// File: rtl/pwm_sr_core.sv
module pwm_sr_core (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  input  logic token_i,
  input  logic trip_i,
  output logic latch_q_o,
  output logic latch_d_o
);

  logic set_req;
  logic upd_en;
  logic latch_q;
  logic latch_d;

  // Reset-dominant next state: the trip overrides any set in the same cycle.
  always_comb begin
    set_req = fall_i & token_i;
    upd_en  = trip_i | set_req;
    if (trip_i) begin
      latch_d = 1'b0;
    end else if (set_req) begin
      latch_d = 1'b1;
    end else begin
      latch_d = latch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (upd_en) begin
      latch_q <= latch_d;
    end
  end

  assign latch_q_o = latch_q;
  assign latch_d_o = latch_d;

endmodule

// File: rtl/pwm_deadtime_seq.sv
module pwm_deadtime_seq
  import pwm_dt_pkg::*;
#(
  parameter int DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            latch_d_i,
  input  logic [DT_W-1:0] dead_cfg_i,
  output logic            hs_en_o,
  output logic            ls_en_o
);

  localparam logic [DT_W-1:0] GAP_MIN = DT_W'(1);

  drv_state_e      state_q, state_d;
  logic [DT_W-1:0] cnt_q, cnt_d;
  logic [DT_W-1:0] gap_len;
  logic [DT_W-1:0] gap_load;
  logic            hs_q, ls_q;
  logic            hs_d, ls_d;

  always_comb begin
    gap_len  = (dead_cfg_i == '0) ? GAP_MIN : dead_cfg_i;
    gap_load = gap_len - GAP_MIN;
    state_d  = state_q;
    cnt_d    = cnt_q;
    case (state_q)
      ST_LOW_ON: begin
        if (latch_d_i) begin
          state_d = ST_GAP_TO_HIGH;
          cnt_d   = gap_load;
        end
      end
      ST_GAP_TO_HIGH: begin
        if (!latch_d_i) begin
          state_d = ST_GAP_TO_LOW;
          cnt_d   = gap_load;
        end else if (cnt_q == '0) begin
          state_d = ST_HIGH_ON;
        end else begin
          cnt_d = cnt_q - GAP_MIN;
        end
      end
      ST_HIGH_ON: begin
        if (!latch_d_i) begin
          state_d = ST_GAP_TO_LOW;
          cnt_d   = gap_load;
        end
      end
      ST_GAP_TO_LOW: begin
        if (latch_d_i) begin
          state_d = ST_GAP_TO_HIGH;
          cnt_d   = gap_load;
        end else if (cnt_q == '0) begin
          state_d = ST_LOW_ON;
        end else begin
          cnt_d = cnt_q - GAP_MIN;
        end
      end
      default: begin
        state_d = ST_GAP_TO_LOW;
        cnt_d   = '0;
      end
    endcase
    hs_d = (state_d == ST_HIGH_ON);
    ls_d = (state_d == ST_LOW_ON);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GAP_TO_LOW;
      cnt_q   <= '0;
      hs_q    <= 1'b0;
      ls_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hs_q    <= hs_d;
      ls_q    <= ls_d;
    end
  end

  assign hs_en_o = hs_q;
  assign ls_en_o = ls_q;

endmodule

// File: rtl/pwm_phase_latch.sv
module pwm_phase_latch #(
  parameter int DT_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwm_clk_i,
  input  logic            token_i,
  input  logic            trip_i,
  input  logic [DT_W-1:0] dead_cfg_i,
  output logic            hs_en_o,
  output logic            ls_en_o,
  output logic            dis_en_o
);

  logic rst_sync_n;
  logic pwm_fall;
  logic latch_q;
  logic latch_d;

  pwm_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_fall_detect u_fall (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pulse_i (pwm_clk_i),
    .fall_o  (pwm_fall)
  );

  pwm_sr_core u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .fall_i    (pwm_fall),
    .token_i   (token_i),
    .trip_i    (trip_i),
    .latch_q_o (latch_q),
    .latch_d_o (latch_d)
  );

  pwm_deadtime_seq #(.DT_W(DT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .latch_d_i  (latch_d),
    .dead_cfg_i (dead_cfg_i),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o)
  );

  assign dis_en_o = ~latch_q;

endmodule

// File: rtl/pwm_phase_latch_chk.sv
module pwm_phase_latch_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_clk_i,
  input logic token_i,
  input logic trip_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic dis_en_o
);

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o)); // R9

  AST_HS_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_en_o) |-> $past(!ls_en_o)); // R6

  AST_LS_RISE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> $past(!hs_en_o)); // R7

  AST_TRIP_DROPS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> !hs_en_o); // R3

  AST_TRIP_DISCHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> dis_en_o); // R4

  AST_SET_NEEDS_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dis_en_o) |-> ($past(token_i) && $past(!trip_i) && $past(!pwm_clk_i))); // R1

  AST_HS_NOT_DISCHARGING: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en_o |-> !dis_en_o); // R10

endmodule

bind pwm_phase_latch pwm_phase_latch_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pwm_clk_i (pwm_clk_i),
  .token_i   (token_i),
  .trip_i    (trip_i),
  .hs_en_o   (hs_en_o),
  .ls_en_o   (ls_en_o),
  .dis_en_o  (dis_en_o)
);

// File: tb/pwm_phase_latch_bench.sv
`timescale 1ns/1ps
module pwm_phase_latch_bench;

  logic       clk;
  logic       rst_n;
  logic       pwm_clk_i;
  logic       token_i;
  logic       trip_i;
  logic [3:0] dead_cfg_i;
  logic       hs_en_o;
  logic       ls_en_o;
  logic       dis_en_o;

  int n_chk;
  int n_fail;
  int n_overlap;
  bit done;

  pwm_phase_latch u_pwm_phase_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_clk_i  (pwm_clk_i),
    .token_i    (token_i),
    .trip_i     (trip_i),
    .dead_cfg_i (dead_cfg_i),
    .hs_en_o    (hs_en_o),
    .ls_en_o    (ls_en_o),
    .dis_en_o   (dis_en_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && hs_en_o && ls_en_o) n_overlap++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Falling pulse edge with the given token/trip; returns at the first
  // sample taken after the edge that acts on it.
  task automatic do_fall(input bit tok, input bit trp);
    @(negedge clk); pwm_clk_i = 1'b1; token_i = 1'b0; trip_i = 1'b0;
    @(negedge clk); pwm_clk_i = 1'b0; token_i = tok; trip_i = trp;
    @(negedge clk); token_i = 1'b0; trip_i = 1'b0;
  endtask

  task automatic do_trip();
    @(negedge clk); trip_i = 1'b1;
    @(negedge clk); trip_i = 1'b0;
  endtask

  function automatic int gap_of(input int cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  initial begin
    n_chk = 0; n_fail = 0; n_overlap = 0; done = 0;
    rst_n = 1'b0; pwm_clk_i = 1'b0; token_i = 1'b0; trip_i = 1'b0;
    dead_cfg_i = 4'd3;
    repeat (3) @(negedge clk);
    chk("R11 hs in reset", hs_en_o, 0);
    chk("R11 ls in reset", ls_en_o, 0);
    chk("R11 dis in reset", dis_en_o, 1);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R11 ls after release", ls_en_o, 1);
    chk("R11 hs after release", hs_en_o, 0);

    // R2: no token
    do_fall(1'b0, 1'b0);
    repeat (3) @(negedge clk);
    chk("R2 no token dis", dis_en_o, 1);
    chk("R2 no token ls", ls_en_o, 1);
    // R2: rising edge and held level with token high
    @(negedge clk); pwm_clk_i = 1'b1; token_i = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 rising edge dis", dis_en_o, 1);
    chk("R2 rising edge ls", ls_en_o, 1);
    token_i = 1'b0;

    // R4: set and trip together
    do_fall(1'b1, 1'b1);
    chk("R4 dominant dis", dis_en_o, 1);
    repeat (4) @(negedge clk);
    chk("R4 dominant hs", hs_en_o, 0);
    chk("R4 dominant ls", ls_en_o, 1);

    // R6 R7 R8: sweep every gap setting
    for (int cfg = 0; cfg < 16; cfg++) begin
      int cnt;
      int bad;
      dead_cfg_i = 4'(cfg);
      do_fall(1'b1, 1'b0);
      chk("R1 set dis", dis_en_o, 0);
      chk("R6 ls drops at set", ls_en_o, 0);
      cnt = 0; bad = 0;
      while (!hs_en_o && cnt < 40) begin
        @(negedge clk); cnt++;
        if (ls_en_o) bad++;
      end
      chk((cfg == 0) ? "R8 gap to high for zero" : "R6 gap to high", cnt, gap_of(cfg));
      chk("R6 ls low in gap", bad, 0);
      chk("R10 dis low while high", dis_en_o, 0);
      do_trip();
      chk("R3 trip dis", dis_en_o, 1);
      chk("R7 hs drops at clear", hs_en_o, 0);
      cnt = 0; bad = 0;
      while (!ls_en_o && cnt < 40) begin
        @(negedge clk); cnt++;
        if (hs_en_o) bad++;
      end
      chk((cfg == 0) ? "R8 gap to low for zero" : "R7 gap to low", cnt, gap_of(cfg));
      chk("R7 hs low in gap", bad, 0);
    end

    // R5: stays set over further pulses
    dead_cfg_i = 4'd2;
    do_fall(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R5 hs on", hs_en_o, 1);
    for (int k = 0; k < 3; k++) begin
      do_fall(1'b1, 1'b0);
      chk("R5 hs held", hs_en_o, 1);
      chk("R5 dis held low", dis_en_o, 0);
      chk("R5 ls held low", ls_en_o, 0);
    end
    do_trip();
    repeat (4) @(negedge clk);
    chk("R7 back to low", ls_en_o, 1);

    // R12: trip during gap toward high side
    dead_cfg_i = 4'd8;
    do_fall(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    chk("R12 hs still low", hs_en_o, 0);
    do_trip();
    begin
      int cnt;
      int hs_seen;
      cnt = 0; hs_seen = 0;
      while (!ls_en_o && cnt < 40) begin
        @(negedge clk); cnt++;
        if (hs_en_o) hs_seen++;
      end
      chk("R12 full gap after abort", cnt, 8);
      chk("R12 hs never rose", hs_seen, 0);
    end

    chk("R9 overlap cycles", n_overlap, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule